// File: doc/BRIEF.md
# Masked Alarm Comparator with Standby Interrupt

This block keeps a small alarm memory of BCD digits, laid out exactly like the time-of-day counter that sits beside it. On every millisecond tick it compares that memory digit by digit against the live counter value and holds the outcome as a match flag. A digit in memory can be turned into a wildcard, so an alarm can be set for a particular time of day, hour or minute without caring about the digits above it. The match flag drives a level-sensitive standby request. This request is an open-drain style "pull low" enable that software can switch on or off.

Software reaches the memory, a memory clear command and the standby enable through a simple byte-wide register bus. When the power-ok input is low, the bus is cut off and ignores every write. The comparison and the standby request keep working, so a standby alarm programmed beforehand still fires.

Top module: `alarm_cmp_unit`

## Requirements
- R1: After a synchronous reset, every alarm digit reads zero, `match_valid` is 0 and `sby_pull_low` is 0.
- R2: A bus write to addresses 08h..0Fh stores the byte in alarm byte (address - 08h). Bits [3:0] hold the lower digit and bits [7:4] hold the upper digit. Reading the same address with `bus_sel` high returns the byte combinationally. Two nibbles have no storage and always read 0: the low nibble of 08h (digit 0) and the high nibble of 0Dh (digit 11).
- R3: Digit i of the time counter is `cnt_time[4i+3:4i]`. The compare is true when every stored digit equals its counter digit.
- R4: A stored digit whose bits [3:2] are both 1 matches any counter value.
- R5: Some counter bits are unused, and these count as zero. Per digit, the used bits are F for digits 1-4, 6, 8, 12 and 14. They are 7 for digits 5, 7 and 10, 3 for digits 9 and 13, and 1 for digit 15. A stored 1 in an unused bit position can therefore never match unless the digit is a wildcard.
- R6: Counter digits 0 and 11 never take part in the compare.
- R7: `match_valid` takes the compare of the counter value present one clock after a `tick_1k` pulse. It changes on the second rising edge after the tick cycle and holds between ticks.
- R8: Writing FFh to address 13h clears all alarm digits. Any other value written there has no effect.
- R9: A write to address 16h sets the standby enable from bit 0. `sby_pull_low` is enable AND `match_valid`. This is a level, so enabling while a match is held asserts it on the next cycle.
- R10: While `pwr_ok` is 0, the block ignores bus writes (RAM, clear, enable) and `bus_rdata` reads 0. Compare, latching and `sby_pull_low` keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | High: bus interface enabled; low: bus cut off |
| bus_sel | input | 1 | Bus access select, active high |
| bus_wr | input | 1 | Write strobe, active high, qualified by bus_sel |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for addresses 08h..0Fh, else 0 |
| tick_1k | input | 1 | One-cycle pulse per counter update |
| cnt_time | input | 64 | Live counter, 16 BCD digits |
| match_valid | output | 1 | Latched compare result |
| sby_pull_low | output | 1 | Standby request: 1 means drive the line low |

## Verification
Bus writes land at the clock edge that ends the write cycle. Read data is combinational, so it is checked half a cycle after the address is set. A compare result is due at the second rising edge after the tick cycle. The bench checks it at the falling edge that follows, and also checks at the falling edge before that edge that the old value still holds. A standby enable write shows on `sby_pull_low` at the falling edge right after the write edge. Reference values come from a bench model of the alarm memory and a mask-aware compare function.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

    parameter int unsigned NUM_BYTES  = 8;
    parameter int unsigned BYTE_W     = 8;
    parameter int unsigned DIGIT_W    = 4;
    parameter int unsigned ADDR_W     = 5;
    localparam int unsigned NUM_DIGITS = NUM_BYTES * (BYTE_W / DIGIT_W);
    localparam int unsigned IDX_W      = $clog2(NUM_BYTES);
    localparam int unsigned PAGE_W     = ADDR_W - IDX_W;
    localparam int unsigned CNT_W      = NUM_DIGITS * DIGIT_W;

    localparam logic [PAGE_W-1:0] RAM_PAGE   = PAGE_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_CLEAR = ADDR_W'(5'h13);
    localparam logic [ADDR_W-1:0] ADDR_SBY   = ADDR_W'(5'h16);
    localparam logic [BYTE_W-1:0] CLEAR_KEY  = '1;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [BYTE_W-1:0]  byte_t;

    typedef struct packed {
        logic             rd_ram;
        logic             wr_ram;
        logic             clr_ram;
        logic             wr_sby;
        logic [IDX_W-1:0] idx;
        byte_t            data;
    } bus_req_t;

    // digits with no alarm storage and no part in the compare
    function automatic logic digit_present(input int unsigned i);
        return !(i == 0 || i == 11);
    endfunction

    // bits of each counter digit that carry BCD information
    function automatic digit_t used_bits(input int unsigned i);
        case (i)
            5, 7, 10: return 4'h7;
            9, 13:    return 4'h3;
            15:       return 4'h1;
            0, 11:    return 4'h0;
            default:  return 4'hF;
        endcase
    endfunction

    function automatic byte_t byte_store_mask(input int unsigned b);
        byte_t m;
        m[DIGIT_W-1:0]      = digit_present(2*b)   ? '1 : '0;
        m[BYTE_W-1:DIGIT_W] = digit_present(2*b+1) ? '1 : '0;
        return m;
    endfunction

    function automatic logic digit_hit(input digit_t stored, input digit_t live,
                                       input digit_t used);
        return (stored[DIGIT_W-1 -: 2] == 2'b11) || (stored == (live & used));
    endfunction

endpackage

// File: rtl/alarm_bus_decode.sv
module alarm_bus_decode
    import alarm_cmp_pkg::*;
(
    input  logic              pwr_ok,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  byte_t             bus_wdata,
    output bus_req_t          req
);
    logic active;
    logic in_ram;

    always_comb begin
        active      = pwr_ok && bus_sel;
        in_ram      = (bus_addr[ADDR_W-1 -: PAGE_W] == RAM_PAGE);
        req.rd_ram  = active && in_ram;
        req.wr_ram  = active && bus_wr && in_ram;
        req.clr_ram = active && bus_wr && (bus_addr == ADDR_CLEAR) && (bus_wdata == CLEAR_KEY);
        req.wr_sby  = active && bus_wr && (bus_addr == ADDR_SBY);
        req.idx     = bus_addr[IDX_W-1:0];
        req.data    = bus_wdata;
    end
endmodule

// File: rtl/alarm_ram.sv
module alarm_ram
    import alarm_cmp_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  bus_req_t                            req,
    output logic [NUM_DIGITS-1:0][DIGIT_W-1:0]  ram_digits,
    output byte_t                               rd_data
);
    logic [NUM_BYTES-1:0][BYTE_W-1:0] ram_bytes;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cell
        if (digit_present(g)) begin : g_store
            digit_t cell_q;
            always_ff @(posedge clk) begin
                if (rst || req.clr_ram)
                    cell_q <= '0;
                else if (req.wr_ram && req.idx == IDX_W'(g / 2))
                    cell_q <= req.data[(g % 2) * DIGIT_W +: DIGIT_W];
            end
            assign ram_digits[g] = cell_q;
        end else begin : g_none
            assign ram_digits[g] = '0;
        end
    end

    assign ram_bytes = ram_digits;
    assign rd_data   = req.rd_ram ? ram_bytes[req.idx] : '0;

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        req.clr_ram |=> (ram_digits == '0));

    assert_write_R2: assert property (@(posedge clk) disable iff (rst)
        req.wr_ram |=> (ram_bytes[$past(req.idx)] ==
                        ($past(req.data) & byte_store_mask($past(req.idx)))));
endmodule

// File: rtl/alarm_digit_cmp.sv
module alarm_digit_cmp
    import alarm_cmp_pkg::*;
(
    input  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] ram_digits,
    input  logic [CNT_W-1:0]                   cnt_time,
    output logic                               all_hit
);
    logic [NUM_DIGITS-1:0] hit;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        if (digit_present(g)) begin : g_cmp
            assign hit[g] = digit_hit(ram_digits[g], cnt_time[g*DIGIT_W +: DIGIT_W],
                                      used_bits(g));
        end else begin : g_skip
            assign hit[g] = 1'b1;
        end
    end

    assign all_hit = &hit;
endmodule

// File: rtl/alarm_match_latch.sv
module alarm_match_latch
    import alarm_cmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_1k,
    input  bus_req_t req,
    input  logic     all_hit,
    output logic     match_q,
    output logic     sby_pull_low
);
    logic tick_d;
    logic sby_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_d   <= 1'b0;
            match_q  <= 1'b0;
            sby_en_q <= 1'b0;
        end else begin
            tick_d <= tick_1k;
            if (tick_d)
                match_q <= all_hit;
            if (req.wr_sby)
                sby_en_q <= req.data[0];
        end
    end

    assign sby_pull_low = sby_en_q && match_q;

    assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(tick_d) |-> $stable(match_q));

    assert_sby_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sby_pull_low) |-> ($past(tick_d) || $past(req.wr_sby)));

    assert_no_wr_sby_R10: assert property (@(posedge clk) disable iff (rst)
        !req.wr_sby |=> $stable(sby_en_q));
endmodule

// File: rtl/alarm_cmp_unit.sv
module alarm_cmp_unit
    import alarm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_1k,
    input  logic [CNT_W-1:0]  cnt_time,
    output logic              match_valid,
    output logic              sby_pull_low
);
    bus_req_t                           req;
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0] ram_digits;
    logic                               all_hit;

    alarm_bus_decode u_dec (
        .pwr_ok    (pwr_ok),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req       (req)
    );

    alarm_ram u_ram (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .ram_digits (ram_digits),
        .rd_data    (bus_rdata)
    );

    alarm_digit_cmp u_cmp (
        .ram_digits (ram_digits),
        .cnt_time   (cnt_time),
        .all_hit    (all_hit)
    );

    alarm_match_latch u_lat (
        .clk          (clk),
        .rst          (rst),
        .tick_1k      (tick_1k),
        .req          (req),
        .all_hit      (all_hit),
        .match_q      (match_valid),
        .sby_pull_low (sby_pull_low)
    );

    assert_pwrdown_ram_R10: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> $stable(ram_digits));

    assert_pwrdown_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> (bus_rdata == '0));
endmodule

// File: tb/alarm_cmp_unit_tb.sv
module alarm_cmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        pwr_ok;
    logic        bus_sel;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        tick_1k;
    logic [63:0] cnt_time;
    logic        match_valid;
    logic        sby_pull_low;

    int   n_checks = 0;
    int   n_errors = 0;
    logic done = 1'b0;
    logic [63:0] ram_m;
    logic        en_m;

    always #4 clk = ~clk;

    alarm_cmp_unit u_dut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_1k(tick_1k), .cnt_time(cnt_time), .match_valid(match_valid),
        .sby_pull_low(sby_pull_low)
    );

    function automatic logic [3:0] ref_used(input int i);
        if (i == 0 || i == 11) return 4'h0;
        if (i == 5 || i == 7 || i == 10) return 4'h7;
        if (i == 9 || i == 13) return 4'h3;
        if (i == 15) return 4'h1;
        return 4'hF;
    endfunction

    function automatic logic ref_has(input int i);
        return (i != 0) && (i != 11);
    endfunction

    function automatic logic ref_match(input logic [63:0] ram, input logic [63:0] cnt);
        for (int i = 0; i < 16; i++) begin
            logic [3:0] r;
            r = ram[4*i +: 4];
            if (ref_has(i) && !(r[3:2] == 2'b11 || r == (cnt[4*i +: 4] & ref_used(i))))
                return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (pwr_ok) begin
            if (a[4:3] == 2'b01)
                for (int k = 0; k < 2; k++)
                    if (ref_has(2*a[2:0] + k)) ram_m[8*a[2:0] + 4*k +: 4] = d[4*k +: 4];
            if (a == 5'h13 && d == 8'hFF) ram_m = '0;
            if (a == 5'h16) en_m = d[0];
        end
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // tick, then sample after the second rising edge
    task automatic do_tick(input logic [63:0] c, output logic early);
        @(negedge clk);
        cnt_time = c; tick_1k = 1'b1;
        @(negedge clk);
        tick_1k = 1'b0;
        early = match_valid;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic        early;
        logic        prev;
        logic [63:0] c;
        int          seed_v;
        seed_v = $urandom(32'd2718);
        rst = 1'b1; pwr_ok = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_wdata = '0; tick_1k = 1'b0; cnt_time = '0; ram_m = '0; en_m = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 match", {63'd0, match_valid}, 64'd0);
        check("R1 pull", {63'd0, sby_pull_low}, 64'd0);
        bus_read(5'h0B, rd); check("R1 ram", {56'd0, rd}, 64'd0);

        // R2 storage and missing nibbles
        bus_write(5'h08, 8'hA5); bus_read(5'h08, rd); check("R2 08h", {56'd0, rd}, 64'hA0);
        bus_write(5'h0D, 8'h37); bus_read(5'h0D, rd); check("R2 0Dh", {56'd0, rd}, 64'h07);
        bus_write(5'h0B, 8'h59); bus_read(5'h0B, rd); check("R2 0Bh", {56'd0, rd}, 64'h59);
        bus_read(5'h10, rd); check("R2 out of range", {56'd0, rd}, 64'd0);

        // R8 clear key
        bus_write(5'h13, 8'h12); bus_read(5'h0B, rd); check("R8 no clear", {56'd0, rd}, 64'h59);
        bus_write(5'h13, 8'hFF); bus_read(5'h0B, rd); check("R8 clear", {56'd0, rd}, 64'd0);
        bus_read(5'h08, rd); check("R8 clear 08h", {56'd0, rd}, 64'd0);

        // R3 exact match, R7 latency and hold
        bus_write(5'h0B, 8'h59); bus_write(5'h0C, 8'h10);
        c = 64'h0000_0010_5900_0000;
        do_tick(c, early);
        check("R7 not yet", {63'd0, early}, 64'd0);
        check("R3 match", {63'd0, match_valid}, 64'd1);
        @(negedge clk); cnt_time = 64'h0000_0011_5900_0000;
        repeat (5) @(negedge clk);
        check("R7 hold", {63'd0, match_valid}, 64'd1);
        do_tick(64'h0000_0011_5900_0000, early);
        check("R7 early old", {63'd0, early}, 64'd1);
        check("R3 mismatch", {63'd0, match_valid}, 64'd0);

        // R4 wildcard on hour units
        bus_write(5'h0C, 8'h1C);
        do_tick(64'h0000_0017_5900_0000, early);
        check("R4 wildcard", {63'd0, match_valid}, 64'd1);

        // R6 ignored digits 0 and 11
        do_tick(64'h0000_A017_5900_000F, early);
        check("R6 ignored", {63'd0, match_valid}, 64'd1);

        // R5 unused counter bits
        do_tick(64'h00C0_0097_5900_0000, early);
        check("R5 unused cnt bits zero", {63'd0, match_valid}, 64'd1);
        bus_write(5'h0F, 8'h20);
        do_tick(64'h2000_0017_5900_0000, early);
        check("R5 stored unused bit", {63'd0, match_valid}, 64'd0);
        bus_write(5'h0F, 8'h00);

        // R9 level enable
        do_tick(64'h0000_0017_5900_0000, early);
        check("R9 pre", {63'd0, sby_pull_low}, 64'd0);
        bus_write(5'h16, 8'h01);
        check("R9 immediate", {63'd0, sby_pull_low}, 64'd1);
        bus_write(5'h16, 8'h00);
        check("R9 disabled", {63'd0, sby_pull_low}, 64'd0);
        bus_write(5'h16, 8'h01);

        // R10 power down
        @(negedge clk); pwr_ok = 1'b0;
        bus_write(5'h0B, 8'h33); bus_write(5'h16, 8'h00); bus_write(5'h13, 8'hFF);
        check("R10 pull kept", {63'd0, sby_pull_low}, 64'd1);
        bus_read(5'h0C, rd); check("R10 rdata", {56'd0, rd}, 64'd0);
        do_tick(64'h0000_0017_5800_0000, early);
        check("R10 compare runs", {63'd0, sby_pull_low}, 64'd0);
        do_tick(64'h0000_0017_5900_0000, early);
        check("R10 alarm fires", {63'd0, sby_pull_low}, 64'd1);
        @(negedge clk); pwr_ok = 1'b1;
        bus_read(5'h0B, rd); check("R10 ram kept", {56'd0, rd}, 64'h59);

        // random mix: R2 R3 R4 R5 R7 R9
        for (int it = 0; it < 40; it++) begin
            for (int b = 8; b < 16; b++) begin
                logic [7:0] d;
                d = 8'($urandom);
                if ($urandom % 3 != 0) d[7:6] = 2'b11;
                bus_write(5'(b), d);
            end
            if ($urandom % 2 == 0) bus_write(5'h16, 8'($urandom));
            c = 64'({$urandom, $urandom});
            if ($urandom % 2 == 0)
                for (int i = 0; i < 16; i++)
                    if (ram_m[4*i+3 -: 2] != 2'b11)
                        c[4*i +: 4] = (ram_m[4*i +: 4] & ref_used(i)) | (c[4*i +: 4] & ~ref_used(i));
            prev = match_valid;
            do_tick(c, early);
            check("R7 random early", {63'd0, early}, {63'd0, prev});
            check("R3 random match", {63'd0, match_valid}, {63'd0, ref_match(ram_m, c)});
            check("R9 random pull", {63'd0, sby_pull_low}, {63'd0, en_m & ref_match(ram_m, c)});
            bus_read(5'(8 + it % 8), rd);
            check("R2 random read", {56'd0, rd}, {56'd0, ram_m[8*(it%8) +: 8]});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule